// File: doc/BRIEF.md
# Sleep-State Power-IC Signaling Sequencer

This block drives the control pins toward an external power IC while the core domain goes into a low-power state and comes back out of it. A level request picks the next state: on, retention, sleep or off. The block sets exactly one automatic low-power mode. It drops the clock-request pin. For off it takes one of two paths. One path lowers the off-mode pin, which lets the power IC take the rails all the way to zero. The other path issues a voltage command to the I2C channel, which can only reach 600 mV. After that the block counts the required setup time in ticks of the 32 kHz clock before it reports the state as reached.

Each path has its own setup count, computed from the configuration inputs. Retention and I2C-signaled off use a voltage ramp count, (on voltage − idle voltage) / slew × (system clock in MHz / 8 + 1). Pin-signaled off uses the oscillator setup time converted to 32 kHz ticks, rounded up, minus a fixed voltage offset of 488 µs (16 ticks). On wakeup the pins are restored in the reverse order. The same count is waited again before done rises.

Top module: `pmic_sleep_seq`

## Requirements
- R1: After reset, clkreq_o=1, offmode_n_o=1, vcmd_req_o=0, vcmd_kind_o=0, auto_mode_o=000 and done_o=1.
- R2: auto_mode_o has at most one bit set: bit0 is retention, bit1 is sleep, bit2 is off. It is set in the cycle after a low-power request is accepted, and it reads 000 once the block is back awake.
- R3: req_state encodes 0=on, 1=retention, 2=sleep, 3=off. A retention request drops clkreq_o one cycle after the request and pulses vcmd_req_o for one cycle in that same cycle, with vcmd_kind_o=1. offmode_n_o stays high.
- R4: An off request with off_pin_sel=1 drops clkreq_o one cycle after the request and drops offmode_n_o in the following cycle. No voltage command is issued.
- R5: An off request with off_pin_sel=0 pulses vcmd_req_o with vcmd_kind_o=3 and drops clkreq_o. offmode_n_o stays high.
- R6: A sleep request drops clkreq_o, issues no command and uses a setup count of zero.
- R7: The retention and I2C-off setup count is ((v_on − v_idle) / slew) × (sysclk_mhz/8 + 1), using integer division. It is 0 when v_idle ≥ v_on or when slew = 0.
- R8: The pin-off setup count is ceil(osc_us × 32768 / 10^6) − 16, with a floor of 0. An osc_us of 0 is treated as 10000 µs.
- R9: The timer counts down only on tick_32k. done_o rises one clock cycle after the Nth tick. With a count of zero, done_o rises two cycles after the stage's pin step.
- R10: When on is requested from a low state, offmode_n_o returns high one cycle after the request and clkreq_o returns high one cycle later. A path that used I2C issues a command with vcmd_kind_o=0. done_o rises after the same count as on entry, and auto_mode_o clears at that point.
- R11: While low, a request for any other low-power state is ignored. Pins, mode, command and done stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle pulse per 32 kHz period |
| req_state | input | 2 | Requested next state (0 on, 1 ret, 2 sleep, 3 off) |
| off_pin_sel | input | 1 | Off uses the off-mode pin instead of an I2C command |
| v_on | input | V_W | On voltage, mV |
| v_ret | input | V_W | Retention voltage, mV |
| v_off | input | V_W | Off voltage for the I2C path, mV |
| slew | input | SLEW_W | Power-IC slew, mV per µs |
| sysclk_mhz | input | MHZ_W | System clock rate, MHz |
| osc_setup_us | input | US_W | Oscillator setup time in µs, 0 = unset |
| clkreq_o | output | 1 | Clock-request pin, active high |
| offmode_n_o | output | 1 | Off-mode pin, active low |
| vcmd_req_o | output | 1 | One-cycle voltage command request |
| vcmd_kind_o | output | 2 | Command target, same encoding as req_state |
| auto_mode_o | output | 3 | One-hot automatic mode |
| done_o | output | 1 | Requested state reached |

## Verification
The request is applied at a falling edge. The clock-request drop, the command pulse and the mode bits are all due one rising edge later, and the off-mode pin step is due one edge after that. The bench samples at the falling edge that follows each of these edges. Ticks are driven as one-cycle pulses with one idle cycle between them. done_o is checked low after N−1 ticks and high right after the Nth tick sequence has ended, which places it on the single edge where the timer reaches zero and the state machine sees it. Wakeup is checked the same way, with the pin order taken from the two consecutive samples.

// File: rtl/pmic_seq_pkg.sv
package pmic_seq_pkg;

    typedef enum logic [1:0] {
        PST_ON    = 2'd0,
        PST_RET   = 2'd1,
        PST_SLEEP = 2'd2,
        PST_OFF   = 2'd3
    } pst_e;

    typedef enum logic [2:0] {
        SQ_AWAKE,
        SQ_ENTER,
        SQ_WAIT_DN,
        SQ_LOW,
        SQ_WAKE,
        SQ_WAIT_UP
    } sq_e;

    typedef struct packed {
        logic off;
        logic sleep;
        logic ret;
    } auto_t;

    localparam int unsigned TICK_HZ        = 32768;
    localparam int unsigned USEC_PER_S     = 1000000;
    localparam int unsigned OSC_DEFAULT_US = 10000;
    localparam int unsigned VOFFSET_US     = 488;
    localparam int unsigned CLK_DIV_MHZ    = 8;

    // ceil(us * 32768 / 1e6)
    function automatic logic [31:0] usec_to_ticks(input logic [31:0] us);
        logic [63:0] prod;
        prod = 64'(us) * 64'(TICK_HZ) + 64'(USEC_PER_S - 1);
        return 32'(prod / 64'(USEC_PER_S));
    endfunction

    function automatic logic [31:0] ramp_ticks(input logic [31:0] v_hi,
                                               input logic [31:0] v_lo,
                                               input logic [31:0] slew,
                                               input logic [31:0] mhz);
        if (v_hi <= v_lo || slew == 32'd0)
            return 32'd0;
        return ((v_hi - v_lo) / slew) * (mhz / CLK_DIV_MHZ + 32'd1);
    endfunction

endpackage

// File: rtl/pmic_setup_calc.sv
module pmic_setup_calc
    import pmic_seq_pkg::*;
#(
    parameter int V_W    = 12,
    parameter int SLEW_W = 8,
    parameter int MHZ_W  = 8,
    parameter int US_W   = 16,
    parameter int CNT_W  = 16
) (
    input  logic [V_W-1:0]    v_on,
    input  logic [V_W-1:0]    v_ret,
    input  logic [V_W-1:0]    v_off,
    input  logic [SLEW_W-1:0] slew,
    input  logic [MHZ_W-1:0]  sysclk_mhz,
    input  logic [US_W-1:0]   osc_setup_us,
    output logic [CNT_W-1:0]  ret_cnt,
    output logic [CNT_W-1:0]  offi2c_cnt,
    output logic [CNT_W-1:0]  offpin_cnt
);

    localparam logic [31:0] CNT_MAX     = 32'((64'd1 << CNT_W) - 64'd1);
    localparam logic [31:0] VOFF_TICKS  = usec_to_ticks(32'(VOFFSET_US));

    function automatic logic [CNT_W-1:0] sat(input logic [31:0] v);
        return (v > CNT_MAX) ? CNT_W'(CNT_MAX) : CNT_W'(v);
    endfunction

    logic [31:0] ret_raw, offi2c_raw, osc_us, clk_ticks, pin_raw;

    always_comb begin
        ret_raw    = ramp_ticks(32'(v_on), 32'(v_ret), 32'(slew), 32'(sysclk_mhz));
        offi2c_raw = ramp_ticks(32'(v_on), 32'(v_off), 32'(slew), 32'(sysclk_mhz));
        osc_us     = (osc_setup_us == '0) ? 32'(OSC_DEFAULT_US) : 32'(osc_setup_us);
        clk_ticks  = usec_to_ticks(osc_us);
        pin_raw    = (clk_ticks > VOFF_TICKS) ? (clk_ticks - VOFF_TICKS) : 32'd0;
        ret_cnt    = sat(ret_raw);
        offi2c_cnt = sat(offi2c_raw);
        offpin_cnt = sat(pin_raw);
    end

endmodule

// File: rtl/pmic_tick_timer.sv
module pmic_tick_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R9
    tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/pmic_sleep_seq.sv
module pmic_sleep_seq
    import pmic_seq_pkg::*;
#(
    parameter int V_W    = 12,
    parameter int SLEW_W = 8,
    parameter int MHZ_W  = 8,
    parameter int US_W   = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_32k,
    input  logic [1:0]        req_state,
    input  logic              off_pin_sel,
    input  logic [V_W-1:0]    v_on,
    input  logic [V_W-1:0]    v_ret,
    input  logic [V_W-1:0]    v_off,
    input  logic [SLEW_W-1:0] slew,
    input  logic [MHZ_W-1:0]  sysclk_mhz,
    input  logic [US_W-1:0]   osc_setup_us,
    output logic              clkreq_o,
    output logic              offmode_n_o,
    output logic              vcmd_req_o,
    output logic [1:0]        vcmd_kind_o,
    output logic [2:0]        auto_mode_o,
    output logic              done_o
);

    logic [CNT_W-1:0] ret_cnt, offi2c_cnt, offpin_cnt;
    logic [CNT_W-1:0] sel_cnt, held_cnt, tmr_val;
    logic             tmr_load, tmr_zero;
    sq_e              state;
    pst_e             req;
    auto_t            auto_q;
    logic             use_pin, use_i2c;

    assign req = pst_e'(req_state);

    pmic_setup_calc #(
        .V_W(V_W), .SLEW_W(SLEW_W), .MHZ_W(MHZ_W), .US_W(US_W), .CNT_W(CNT_W)
    ) u_calc (
        .v_on(v_on), .v_ret(v_ret), .v_off(v_off), .slew(slew),
        .sysclk_mhz(sysclk_mhz), .osc_setup_us(osc_setup_us),
        .ret_cnt(ret_cnt), .offi2c_cnt(offi2c_cnt), .offpin_cnt(offpin_cnt)
    );

    always_comb begin
        case (req)
            PST_RET: sel_cnt = ret_cnt;
            PST_OFF: sel_cnt = off_pin_sel ? offpin_cnt : offi2c_cnt;
            default: sel_cnt = '0;
        endcase
        tmr_load = (state == SQ_AWAKE && req != PST_ON) ||
                   (state == SQ_LOW   && req == PST_ON);
        tmr_val  = (state == SQ_AWAKE) ? sel_cnt : held_cnt;
    end

    pmic_tick_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .tick(tick_32k), .zero(tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_AWAKE;
            clkreq_o    <= 1'b1;
            offmode_n_o <= 1'b1;
            vcmd_req_o  <= 1'b0;
            vcmd_kind_o <= PST_ON;
            auto_q      <= '0;
            use_pin     <= 1'b0;
            use_i2c     <= 1'b0;
            held_cnt    <= '0;
        end else begin
            vcmd_req_o <= 1'b0;
            case (state)
                SQ_AWAKE: if (req != PST_ON) begin
                    state    <= SQ_ENTER;
                    clkreq_o <= 1'b0;
                    held_cnt <= sel_cnt;
                    auto_q   <= '{off: req == PST_OFF, sleep: req == PST_SLEEP,
                                  ret: req == PST_RET};
                    if (req == PST_RET || (req == PST_OFF && !off_pin_sel)) begin
                        vcmd_req_o  <= 1'b1;
                        vcmd_kind_o <= req;
                        use_i2c     <= 1'b1;
                    end
                    use_pin <= (req == PST_OFF) && off_pin_sel;
                end
                SQ_ENTER: begin
                    if (use_pin) offmode_n_o <= 1'b0;
                    state <= SQ_WAIT_DN;
                end
                SQ_WAIT_DN: if (tmr_zero) state <= SQ_LOW;
                SQ_LOW: if (req == PST_ON) begin
                    state       <= SQ_WAKE;
                    offmode_n_o <= 1'b1;
                    if (use_i2c) begin
                        vcmd_req_o  <= 1'b1;
                        vcmd_kind_o <= PST_ON;
                    end
                end
                SQ_WAKE: begin
                    clkreq_o <= 1'b1;
                    state    <= SQ_WAIT_UP;
                end
                SQ_WAIT_UP: if (tmr_zero) begin
                    state   <= SQ_AWAKE;
                    auto_q  <= '0;
                    use_pin <= 1'b0;
                    use_i2c <= 1'b0;
                end
                default: state <= SQ_AWAKE;
            endcase
        end
    end

    assign auto_mode_o = auto_q;
    assign done_o      = (state == SQ_AWAKE) || (state == SQ_LOW);

    // R2
    auto_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(auto_mode_o));

    // R4
    off_pin_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(offmode_n_o) |-> !clkreq_o);

    // R10
    wake_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clkreq_o) |-> offmode_n_o);

    // R3
    cmd_clk_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        vcmd_req_o |-> !clkreq_o);

    // R9
    done_after_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(tmr_zero));

endmodule

// File: tb/tb_pmic_sleep_seq.sv
module tb_pmic_sleep_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_32k = 1'b0;
    logic [1:0]  req_state = 2'd0;
    logic        off_pin_sel = 1'b0;
    logic [11:0] v_on = 12'd1200, v_ret = 12'd900, v_off = 12'd600;
    logic [7:0]  slew = 8'd10, sysclk_mhz = 8'd26;
    logic [15:0] osc_setup_us = 16'd0;
    logic        clkreq_o, offmode_n_o, vcmd_req_o, done_o;
    logic [1:0]  vcmd_kind_o;
    logic [2:0]  auto_mode_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmic_sleep_seq dut (
        .clk(clk), .rst(rst), .tick_32k(tick_32k), .req_state(req_state),
        .off_pin_sel(off_pin_sel), .v_on(v_on), .v_ret(v_ret), .v_off(v_off),
        .slew(slew), .sysclk_mhz(sysclk_mhz), .osc_setup_us(osc_setup_us),
        .clkreq_o(clkreq_o), .offmode_n_o(offmode_n_o), .vcmd_req_o(vcmd_req_o),
        .vcmd_kind_o(vcmd_kind_o), .auto_mode_o(auto_mode_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [1:0]  req;
        logic        pin;
        logic [15:0] osc;
        logic [7:0]  mhz;
        logic [15:0] n;
        logic        cmd;
        logic [2:0]  auto_m;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 1'b0, 16'd0,    8'd26, 16'd120, 1'b1, 3'b001},
        '{2'd3, 1'b1, 16'd0,    8'd26, 16'd312, 1'b0, 3'b100},
        '{2'd3, 1'b0, 16'd0,    8'd26, 16'd240, 1'b1, 3'b100},
        '{2'd2, 1'b0, 16'd0,    8'd26, 16'd0,   1'b0, 3'b010},
        '{2'd3, 1'b1, 16'd2000, 8'd26, 16'd50,  1'b0, 3'b100},
        '{2'd3, 1'b1, 16'd100,  8'd26, 16'd0,   1'b0, 3'b100},
        '{2'd1, 1'b0, 16'd0,    8'd12, 16'd60,  1'b1, 3'b001},
        '{2'd3, 1'b0, 16'd0,    8'd38, 16'd300, 1'b1, 3'b100}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick_once();
        tick_32k = 1'b1;
        @(negedge clk);
        tick_32k = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_count(input logic [15:0] n, input string tag);
        if (n == 0) begin
            @(negedge clk);
            check({tag, " zero-count done"}, done_o, 1);
        end else begin
            for (int i = 0; i < int'(n) - 1; i++) tick_once();
            check({tag, " done low before last tick"}, done_o, 0);
            tick_once();
            check({tag, " done after last tick"}, done_o, 1);
        end
    endtask

    task automatic enter_low(input vec_t v, input string tag);
        off_pin_sel  = v.pin;
        osc_setup_us = v.osc;
        sysclk_mhz   = v.mhz;
        @(negedge clk);
        req_state = v.req;
        @(negedge clk);
        check({tag, " R3 clkreq dropped"}, clkreq_o, 0);
        check({tag, " R2 auto mode"}, auto_mode_o, v.auto_m);
        check({tag, " R5 cmd pulse"}, vcmd_req_o, v.cmd);
        if (v.cmd) check({tag, " R3 cmd kind"}, vcmd_kind_o, v.req);
        check({tag, " R4 offmode held first cycle"}, offmode_n_o, 1);
        check({tag, " R9 done low"}, done_o, 0);
        @(negedge clk);
        check({tag, " R4 offmode step"}, offmode_n_o,
              (v.pin && v.req == 2'd3) ? 0 : 1);
        check({tag, " R6 cmd one cycle"}, vcmd_req_o, 0);
        wait_count(v.n, {tag, (v.req == 2'd3 && v.pin) ? " R8" : " R7"});
    endtask

    task automatic wake_up(input vec_t v, input string tag);
        req_state = 2'd0;
        @(negedge clk);
        check({tag, " R10 offmode restored first"}, offmode_n_o, 1);
        check({tag, " R10 clkreq still low"}, clkreq_o, 0);
        check({tag, " R10 wake cmd"}, vcmd_req_o, v.cmd);
        if (v.cmd) check({tag, " R10 wake cmd kind"}, vcmd_kind_o, 0);
        @(negedge clk);
        check({tag, " R10 clkreq restored"}, clkreq_o, 1);
        check({tag, " R10 done low while ramping"}, done_o, v.n == 0 ? 0 : 0);
        wait_count(v.n, {tag, " R10 wake"});
        check({tag, " R2 auto cleared"}, auto_mode_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 clkreq", clkreq_o, 1);
        check("R1 offmode_n", offmode_n_o, 1);
        check("R1 vcmd_req", vcmd_req_o, 0);
        check("R1 vcmd_kind", vcmd_kind_o, 0);
        check("R1 auto", auto_mode_o, 0);
        check("R1 done", done_o, 1);

        for (int k = 0; k < NVEC; k++) begin
            enter_low(VECS[k], $sformatf("vec%0d", k));
            wake_up(VECS[k], $sformatf("vec%0d", k));
        end

        // R7 idle voltage above on voltage gives zero count
        v_ret = 12'd1300;
        enter_low('{2'd1, 1'b0, 16'd0, 8'd26, 16'd0, 1'b1, 3'b001}, "R7 clamp");
        wake_up('{2'd1, 1'b0, 16'd0, 8'd26, 16'd0, 1'b1, 3'b001}, "R7 clamp");
        v_ret = 12'd900;

        // R11 other low-power request while low is ignored
        enter_low(VECS[0], "R11 setup");
        off_pin_sel = 1'b1;
        req_state = 2'd3;
        repeat (4) begin
            @(negedge clk);
            check("R11 offmode unchanged", offmode_n_o, 1);
            check("R11 no cmd", vcmd_req_o, 0);
        end
        check("R11 auto unchanged", auto_mode_o, 3'b001);
        check("R11 done held", done_o, 1);
        check("R11 clkreq held", clkreq_o, 0);
        off_pin_sel = 1'b0;
        wake_up(VECS[0], "R11 wake");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule